// File: doc/BRIEF.md
# Triangular spread-profile generator

This block drives the frequency-offset input of a spread-spectrum clock synthesizer. It runs from a system clock and produces a signed offset code. The code is expressed in parts per ten thousand of the nominal frequency. It follows a periodic triangle whose repetition rate is set by parameters. The downstream loop, oscillator and current DAC take this code and spread the synthesized clock around its nominal frequency. That lowers the peak of the radiated spectrum.

Three inputs set the profile. An enable input turns spreading on and off. A mode input selects center spread or down spread. Center spread swings the offset symmetrically about nominal. Down spread keeps the offset at zero or below, so the clock never runs faster than nominal. A two-bit rate code selects the depth. A one-cycle strobe marks each profile update, so the consumer can latch the new code. Any change to the three inputs restarts the triangle from the zero-offset point.

Internally, a prescaler derived from the system clock frequency paces the updates. A remainder accumulator then walks the triangle with exact endpoints and no multiplier.

Top module: `ssm_tri_mod_gen`

## Requirements
- R1: While enabled, after the m-th update since the last restart the offset equals floor(S·k/N) − D. Here N = 2^HALF_LOG2 and k is the triangle index. The index rises to N, falls to 0 and rises again, and it does not dwell at either end. S is the span (2·D in center mode, D in down mode) and D is the selected depth.
- R2: In center mode (spread_down_i = 0) the offset stays within −D..+D and reaches both +D and −D within one period.
- R3: In down mode (spread_down_i = 1) the offset is never positive and spans 0 down to −D.
- R4: An update, marked by a one-cycle upd_stb_o pulse carrying the new offset, occurs every SYS_CLK_HZ/(MOD_HZ·2·N) cycles. A full triangle period therefore takes SYS_CLK_HZ/MOD_HZ cycles.
- R5: With mod_en_i low, the offset is exactly zero and no strobe is issued.
- R6: A change on mod_en_i, spread_down_i or rate_sel_i sets the offset to zero on the next clock edge and restarts the triangle there. Center mode restarts rising and down mode restarts falling. The first update follows one full update interval later.
- R7: rate_sel_i selects the depth D in parts per ten thousand: code 0 = 50 (0.5%), 1 = 100 (1.0%), 2 = 150 (1.5%), 3 = 300 (3.0%). Any code works with either mode.
- R8: Synchronous reset forces the offset to zero and the strobe low, with the profile in its rising phase and disabled. If mod_en_i is high when reset is released, the profile restarts on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mod_en_i | input | 1 | Spreading enable; low holds the offset at zero |
| spread_down_i | input | 1 | 0 = center spread, 1 = down spread |
| rate_sel_i | input | 2 | Depth code (50/100/150/300 parts per ten thousand) |
| ofs_o | output | 12 | Signed frequency offset, parts per ten thousand of nominal |
| upd_stb_o | output | 1 | One-cycle pulse when ofs_o takes a new profile value |

## Verification
Two results have fixed latencies. A configuration change applied between edges shows as a zero offset right after the next edge. Each profile step then appears exactly one update interval (P cycles) after the previous one, together with its strobe. The bench drives inputs on the falling edge and counts falling edges from the restart edge. At count t it expects the strobe exactly when t is a nonzero multiple of P, and the offset from the triangle index after floor(t/P) updates. Every rate and mode pairing is swept over more than one full period with P = 4 and N = 8. The sweeps also cover mid-profile reconfiguration, an enable toggle and a reset released with enable high.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int OFS_W = 12;
    localparam int SEL_W = 2;

    typedef enum logic {
        SPREAD_CENTER = 1'b0,
        SPREAD_DOWN   = 1'b1
    } spread_e;

    typedef enum logic [SEL_W-1:0] {
        DEPTH_0P5 = 2'd0,
        DEPTH_1P0 = 2'd1,
        DEPTH_1P5 = 2'd2,
        DEPTH_3P0 = 2'd3
    } depth_e;

    typedef struct packed {
        logic    en;
        spread_e mode;
        depth_e  depth;
    } mod_cfg_t;

    // Depth in parts per ten thousand of nominal.
    function automatic logic [OFS_W-1:0] depth_ppt(depth_e d);
        case (d)
            DEPTH_0P5: depth_ppt = OFS_W'(50);
            DEPTH_1P0: depth_ppt = OFS_W'(100);
            DEPTH_1P5: depth_ppt = OFS_W'(150);
            default:   depth_ppt = OFS_W'(300);
        endcase
    endfunction

    // Peak-to-peak span of the triangle.
    function automatic logic [OFS_W-1:0] span_ppt(spread_e m, depth_e d);
        span_ppt = (m == SPREAD_DOWN) ? depth_ppt(d) : (depth_ppt(d) << 1);
    endfunction

endpackage

// File: rtl/ssm_prescaler.sv
module ssm_prescaler #(
    parameter int DIV = 250
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i || tick_o) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    AST_PRESC_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CW'(DIV - 1)); // R4

endmodule

// File: rtl/ssm_tri_core.sv
module ssm_tri_core
    import ssm_pkg::*;
#(
    parameter int HALF_LOG2 = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    restart_i,
    input  logic                    step_i,
    input  mod_cfg_t                cfg_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    localparam int N  = 1 << HALF_LOG2;
    localparam int KW = HALF_LOG2 + 1;

    logic [KW-1:0]        k_q, k_nx;
    logic                 up_q, go_up;
    logic [OFS_W-1:0]     q_q, q_nx, q_up, q_dn;
    logic [HALF_LOG2-1:0] r_q, r_nx, r_dn;
    logic [HALF_LOG2:0]   r_sum;
    logic [OFS_W-1:0]     span, depth, step_q;
    logic [HALF_LOG2-1:0] step_r;
    logic                 borrow;
    logic signed [OFS_W-1:0] ofs_q;

    always_comb begin
        span   = span_ppt(cfg_i.mode, cfg_i.depth);
        depth  = depth_ppt(cfg_i.depth);
        step_q = span >> HALF_LOG2;
        step_r = span[HALF_LOG2-1:0];
        // Reverse at the ends without repeating the extreme value.
        go_up  = up_q ? (k_q != KW'(N)) : (k_q == '0);
        r_sum  = {1'b0, r_q} + {1'b0, step_r};
        q_up   = q_q + step_q + {{(OFS_W-1){1'b0}}, r_sum[HALF_LOG2]};
        borrow = (r_q < step_r);
        r_dn   = r_q - step_r;
        q_dn   = q_q - step_q - {{(OFS_W-1){1'b0}}, borrow};
        q_nx   = go_up ? q_up : q_dn;
        r_nx   = go_up ? r_sum[HALF_LOG2-1:0] : r_dn;
        k_nx   = go_up ? (k_q + 1'b1) : (k_q - 1'b1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            k_q   <= KW'(N / 2);
            up_q  <= 1'b1;
            q_q   <= '0;
            r_q   <= '0;
            ofs_q <= '0;
        end else if (restart_i) begin
            // Zero-offset point: mid-index rising (center) or top falling (down).
            k_q   <= (cfg_i.mode == SPREAD_DOWN) ? KW'(N) : KW'(N / 2);
            up_q  <= (cfg_i.mode != SPREAD_DOWN);
            q_q   <= depth;
            r_q   <= '0;
            ofs_q <= '0;
        end else if (step_i) begin
            k_q   <= k_nx;
            up_q  <= go_up;
            q_q   <= q_nx;
            r_q   <= r_nx;
            ofs_q <= signed'(q_nx) - signed'(depth);
        end
    end

    assign ofs_o = ofs_q;

    AST_INDEX_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        k_q <= KW'(N)); // R1

    AST_TURN_AT_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !restart_i && k_q == KW'(N)) |=> (!up_q && k_q == KW'(N - 1))); // R1

endmodule

// File: rtl/ssm_tri_mod_gen.sv
module ssm_tri_mod_gen
    import ssm_pkg::*;
#(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int MOD_HZ     = 12_500,
    parameter int HALF_LOG2  = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            mod_en_i,
    input  logic                            spread_down_i,
    input  logic [1:0]                      rate_sel_i,
    output logic signed [ssm_pkg::OFS_W-1:0] ofs_o,
    output logic                            upd_stb_o
);
    localparam int N   = 1 << HALF_LOG2;
    localparam int DIV = SYS_CLK_HZ / (MOD_HZ * 2 * N);

    mod_cfg_t cfg_d, cfg_q;
    logic     restart, tick, step, stb_q;

    assign cfg_d   = '{en: mod_en_i, mode: spread_e'(spread_down_i), depth: depth_e'(rate_sel_i)};
    assign restart = (cfg_d != cfg_q);
    assign step    = tick && cfg_q.en && !restart;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '{en: 1'b0, mode: SPREAD_CENTER, depth: DEPTH_0P5};
            stb_q <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            stb_q <= step;
        end
    end

    ssm_prescaler #(.DIV(DIV)) u_presc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (restart || !cfg_q.en),
        .tick_o (tick)
    );

    ssm_tri_core #(.HALF_LOG2(HALF_LOG2)) u_core (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .step_i    (step),
        .cfg_i     (cfg_d),
        .ofs_o     (ofs_o)
    );

    assign upd_stb_o = stb_q;

    // Checking aids derived from the registered configuration.
    logic signed [OFS_W-1:0] lim_s, stp_s;
    assign lim_s = signed'(depth_ppt(cfg_q.depth));
    assign stp_s = signed'(span_ppt(cfg_q.mode, cfg_q.depth) >> HALF_LOG2) + OFS_W'(1);

    AST_CENTER_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_q.en && cfg_q.mode == SPREAD_CENTER) |-> (ofs_o <= lim_s && ofs_o >= -lim_s)); // R2

    AST_DOWN_NONPOS: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_q.en && cfg_q.mode == SPREAD_DOWN) |-> (ofs_o <= 0 && ofs_o >= -lim_s)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_q.en |-> (ofs_o == 0 && !upd_stb_o)); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        restart |=> (ofs_o == 0 && !upd_stb_o)); // R6

    AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_stb_o |-> ((ofs_o - $past(ofs_o)) <= stp_s && (ofs_o - $past(ofs_o)) >= -stp_s)); // R1

    AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_stb_o |=> !upd_stb_o); // R4

endmodule

// File: tb/ssm_tri_mod_gen_bench.sv
`timescale 1ns/1ps
module ssm_tri_mod_gen_bench;
    localparam int SYS = 800_000;
    localparam int MODF = 12_500;
    localparam int L = 3;
    localparam int N = 1 << L;
    localparam int P = SYS / (MODF * 2 * N);   // 4 cycles per update
    localparam int RUN = 2 * N * P + P;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0, dn = 1'b0;
    logic [1:0] rsel = 2'd0;
    logic signed [11:0] ofs;
    logic stb;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    ssm_tri_mod_gen #(.SYS_CLK_HZ(SYS), .MOD_HZ(MODF), .HALF_LOG2(L)) u_ssm_tri_mod_gen (
        .clk_i(clk), .rst_i(rst), .mod_en_i(en), .spread_down_i(dn),
        .rate_sel_i(rsel), .ofs_o(ofs), .upd_stb_o(stb)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100_000) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog: actual %0d cycles, expected fewer than 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R7 depth table.
    function automatic int depth_of(int code);
        case (code)
            0: return 50;
            1: return 100;
            2: return 150;
            default: return 300;
        endcase
    endfunction

    // Expected offset t falling edges after the restart edge.
    function automatic int exp_ofs(int code, int down, int t);
        int d = depth_of(code);
        int s = down ? d : 2 * d;
        int p = ((down ? N : N / 2) + t / P) % (2 * N);
        int k = (p <= N) ? p : 2 * N - p;
        return (s * k) / N - d;
    endfunction

    // Check the profile from the falling edge right after a restart edge.
    task automatic follow(input int code, input int down, input int len);
        for (int t = 0; t <= len; t++) begin
            int e = exp_ofs(code, down, t);
            bit es = (t > 0) && (t % P == 0);
            if (t == 0)
                check(ofs == 0, "R6 restart at zero", int'(ofs), 0);
            else
                check(ofs == e, down ? "R1 R3 R7 down profile" : "R1 R2 R7 center profile",
                      int'(ofs), e);
            check(stb == es, "R4 strobe timing", int'(stb), int'(es));
            if (t < len) @(negedge clk);
        end
    endtask

    task automatic run_cfg(input bit e, input int down, input int code, input int len);
        @(negedge clk);
        en = e; dn = down[0]; rsel = code[1:0];
        @(posedge clk);
        @(negedge clk);
        follow(code, down, len);
    endtask

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(ofs == 0, "R8 offset in reset", int'(ofs), 0);
        check(stb == 0, "R8 strobe in reset", int'(stb), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(ofs == 0, "R8 offset after reset, disabled", int'(ofs), 0);

        // R5: disabled holds zero with every depth and mode
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            dn = c[2]; rsel = c[1:0];
            repeat (2 * P) begin
                @(negedge clk);
                check(ofs == 0, "R5 disabled offset", int'(ofs), 0);
                check(stb == 0, "R5 disabled strobe", int'(stb), 0);
            end
        end

        // R1 R2 R3 R4 R7: sweep every depth in both modes over a full period
        for (int down = 0; down < 2; down++)
            for (int code = 0; code < 4; code++)
                run_cfg(1'b1, down, code, RUN);

        // R6: change depth mid-profile, then change mode mid-profile
        run_cfg(1'b1, 0, 2, 2 * P + 1);
        run_cfg(1'b1, 0, 3, 5 * P + 2);
        run_cfg(1'b1, 1, 3, 3 * P + 1);
        run_cfg(1'b1, 0, 1, RUN);

        // R6: enable toggle restarts with the same configuration
        run_cfg(1'b1, 1, 0, 3 * P);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        check(ofs == 0, "R5 offset after disable", int'(ofs), 0);
        check(stb == 0, "R5 strobe after disable", int'(stb), 0);
        run_cfg(1'b1, 1, 0, RUN);

        // R8: reset with enable high, restart on first edge after release
        @(negedge clk); rst = 1'b1; en = 1'b1; dn = 1'b0; rsel = 2'd2;
        repeat (3) @(negedge clk);
        check(ofs == 0, "R8 offset in reset while enabled", int'(ofs), 0);
        check(stb == 0, "R8 strobe in reset while enabled", int'(stb), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        follow(2, 0, RUN);

        summary();
        $finish;
    end
endmodule